// File: doc/BRIEF.md
# Multichannel CIC Interpolator

This block raises the sample rate of several interleaved channels by an integer factor with a cascaded integrator-comb structure that uses no multipliers. Each input packet carries one sample per channel, channel 0 first. Every sample first passes through a chain of comb (difference) stages at the low rate. The block then issues the packet again, rate-factor minus one times, with zero in place of the comb output. This zero insertion raises the rate. All of these beats pass through an equal number of running-sum integrator stages at the high rate. All comb and integrator state is kept separately for each channel, so the channels share one datapath in time.

Both sides use a valid/ready stream with start and end markers around each packet. The output carries the channel index of every result. The comb and integrator stages are each sized from their own worst-case gain rather than from the output width. Every integrator is a feedback loop, so the block must be reset before its first input.

Top module: `cic_interp`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, out_valid is 0 and all filter state is zero. After reset, in_ready equals out_ready.
- R2: A beat accepted on the input (in_valid and in_ready high at a clock edge) presents its result on out_data with out_valid high in the cycle that follows that edge.
- R3: Each input packet of N_CH beats produces RATE output packets of N_CH beats each. out_channel counts 0 to N_CH-1 within each output packet. out_sop is 1 exactly on channel 0 and out_eop is 1 exactly on channel N_CH-1.
- R4: in_ready is 0 while the RATE-1 zero-insertion packets of the current input are being produced, and whenever out_ready is 0.
- R5: For each channel, the response to a single nonzero input sample A is A times the N_STG-fold convolution of a length RATE*DIFF_DLY all-ones window, taken at the high rate, with the first term on the phase-0 beat of that packet. Other channels stay at zero.
- R6: out_data is a signed value OUT_W = IN_W + N_STG*log2(RATE*DIFF_DLY) - log2(RATE) bits wide, which is 12 bits at the defaults. Any input sequence, including the steady extremes -128 and 127, gives the exact zero-stuffed moving-sum result with no wrap.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_channel, out_sop and out_eop hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset, required before first use |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block accepts an input beat this cycle |
| in_data | input | IN_W | Signed input sample |
| in_sop | input | 1 | Input beat is channel 0; restarts the channel count |
| in_eop | input | 1 | Input beat closes the input packet |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | OUT_W | Signed filter result |
| out_channel | output | CH_W | Channel index of out_data |
| out_sop | output | 1 | Output beat is channel 0 |
| out_eop | output | 1 | Output beat is channel N_CH-1 |

## Verification
The phase-0 result of an input beat is due one clock after that beat is accepted, because only the output register lies between the handshake and the port. The zero-insertion beats follow one per cycle whenever out_ready is high. The bench drives inputs and out_ready just after the falling edge and samples shortly after. It counts a transfer only when valid and ready are both high in that window. Each output is matched, by its position in the stream, against a per-channel zero-stuffed moving-sum model. The bench also checks that the output is present on the cycle after each acceptance, and that in_ready follows the phase implied by the beats produced so far.

// File: rtl/cic_interp_pkg.sv
// Package cic_interp_pkg
// Width rules shared by the comb chain, the integrator chain and the top.
// Assumes RATE >= 2 and DIFF_DLY of 1 or 2.
package cic_interp_pkg;

    // Width of comb stage k (1-based): one bit of growth per difference.
    function automatic int comb_width(int in_w, int k);
        return in_w + k;
    endfunction

    // Width of integrator stage j (1-based), from that stage's gain bound.
    function automatic int integ_width(int in_w, int n, int r, int m, int j);
        return in_w + (n - j) + j * $clog2(r * m) - $clog2(r);
    endfunction

    // Widest value carried between any two stages.
    function automatic int link_width(int in_w, int n, int r, int m);
        int w;
        w = comb_width(in_w, n);
        for (int j = 1; j <= n; j++) begin
            if (integ_width(in_w, n, r, m, j) > w) w = integ_width(in_w, n, r, m, j);
        end
        return w;
    endfunction

endpackage

// File: rtl/cic_comb_chain.sv
// Module cic_comb_chain
// N_STG difference stages y = x - x[n-DIFF_DLY], each keeping DIFF_DLY past
// inputs per channel. The output is combinational from din. State moves only
// on step, for the channel given by ch.
module cic_comb_chain #(
    parameter int IN_W     = 8,
    parameter int N_STG    = 3,
    parameter int DIFF_DLY = 1,
    parameter int N_CH     = 4,
    parameter int CH_W     = 2,
    localparam int OUT_W   = IN_W + N_STG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic [CH_W-1:0]         ch,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [OUT_W-1:0] lnk [0:N_STG];

    assign lnk[0] = OUT_W'(din);

    for (genvar k = 1; k <= N_STG; k++) begin : g_stage
        localparam int WI = cic_interp_pkg::comb_width(IN_W, k - 1);
        logic signed [WI-1:0] dl [N_CH][DIFF_DLY];
        logic signed [WI-1:0] x;
        logic signed [WI:0]   y;

        assign x = WI'(lnk[k-1]);
        assign y = (WI+1)'(x) - (WI+1)'(dl[ch][DIFF_DLY-1]);
        assign lnk[k] = OUT_W'(y);

        // Delay line: push the stage input for the active channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int c = 0; c < N_CH; c++)
                    for (int d = 0; d < DIFF_DLY; d++)
                        dl[c][d] <= '0;
            end else if (step) begin
                dl[ch][0] <= x;
                for (int d = 1; d < DIFF_DLY; d++)
                    dl[ch][d] <= dl[ch][d-1];
            end
        end
    end

    assign dout = lnk[N_STG];
endmodule

// File: rtl/cic_integ_chain.sv
// Module cic_integ_chain
// N_STG running-sum stages at the high rate. Each stage has its own pruned
// width and one accumulator per channel. When zero is set the chain input
// is forced to zero (zero insertion). The output is the updated last-stage sum.
module cic_integ_chain #(
    parameter int IN_W     = 8,
    parameter int N_STG    = 3,
    parameter int RATE     = 4,
    parameter int DIFF_DLY = 1,
    parameter int N_CH     = 4,
    parameter int CH_W     = 2,
    localparam int DIN_W   = IN_W + N_STG,
    localparam int OUT_W   = cic_interp_pkg::integ_width(IN_W, N_STG, RATE, DIFF_DLY, N_STG),
    localparam int LNK_W   = cic_interp_pkg::link_width(IN_W, N_STG, RATE, DIFF_DLY)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    zero,
    input  logic [CH_W-1:0]         ch,
    input  logic signed [DIN_W-1:0] din,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [LNK_W-1:0] lnk [0:N_STG];

    assign lnk[0] = zero ? '0 : LNK_W'(din);

    for (genvar j = 1; j <= N_STG; j++) begin : g_stage
        localparam int W = cic_interp_pkg::integ_width(IN_W, N_STG, RATE, DIFF_DLY, j);
        logic signed [W-1:0] acc [N_CH];
        logic signed [W-1:0] s;

        assign s = acc[ch] + W'(lnk[j-1]);
        assign lnk[j] = LNK_W'(s);

        // Accumulator: keep the new sum of the active channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int c = 0; c < N_CH; c++) acc[c] <= '0;
            end else if (step) begin
                acc[ch] <= s;
            end
        end
    end

    assign dout = OUT_W'(lnk[N_STG]);
endmodule

// File: rtl/cic_interp_seq.sv
// Module cic_interp_seq
// Channel and phase sequencing. Phase 0 takes input beats. Phases 1 to
// RATE-1 emit zero-insertion beats on their own. A beat fires only when
// out_ready is high. in_sop forces channel 0; in_eop or the last channel
// closes the packet.
module cic_interp_seq #(
    parameter int N_CH = 4,
    parameter int RATE = 4,
    parameter int CH_W = 2,
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sop,
    input  logic            in_eop,
    input  logic            out_ready,
    output logic            in_ready,
    output logic            fire,
    output logic            zero_ins,
    output logic [CH_W-1:0] cur_ch,
    output logic            first_ch,
    output logic            last_ch
);
    logic [CH_W-1:0] ch_q;
    logic [PH_W-1:0] ph_q;

    // Beat decode: which channel this beat is and whether it may fire.
    always_comb begin
        zero_ins = (ph_q != '0);
        in_ready = out_ready && !zero_ins;
        fire     = out_ready && (zero_ins || in_valid);
        cur_ch   = (!zero_ins && in_sop) ? '0 : ch_q;
        first_ch = (cur_ch == '0);
        last_ch  = (cur_ch == CH_W'(N_CH - 1)) || (!zero_ins && in_eop);
    end

    // Counters: advance the channel per beat and the phase per packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
            ph_q <= '0;
        end else if (fire) begin
            ch_q <= last_ch ? '0 : cur_ch + 1'b1;
            if (last_ch) ph_q <= (ph_q == PH_W'(RATE - 1)) ? '0 : ph_q + 1'b1;
        end
    end
endmodule

// File: rtl/cic_interp.sv
// Module cic_interp (top)
// Multichannel CIC interpolator: comb chain at the input rate, zero insertion
// by RATE, integrator chain at the high rate, and one output register.
// Assumes RATE >= 2, DIFF_DLY in {1,2}, and a reset before the first input.
module cic_interp #(
    parameter int IN_W     = 8,
    parameter int N_STG    = 3,
    parameter int RATE     = 4,
    parameter int DIFF_DLY = 1,
    parameter int N_CH     = 4,
    localparam int OUT_W   = IN_W + N_STG * $clog2(RATE * DIFF_DLY) - $clog2(RATE),
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int PH_W    = $clog2(RATE),
    localparam int COMB_W  = IN_W + N_STG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_data,
    input  logic                    in_sop,
    input  logic                    in_eop,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_data,
    output logic [CH_W-1:0]         out_channel,
    output logic                    out_sop,
    output logic                    out_eop
);
    logic                     fire, zero_ins, first_ch, last_ch;
    logic [CH_W-1:0]          cur_ch;
    logic signed [COMB_W-1:0] comb_out;
    logic signed [OUT_W-1:0]  integ_out;

    cic_interp_seq #(
        .N_CH(N_CH), .RATE(RATE), .CH_W(CH_W), .PH_W(PH_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .out_ready(out_ready), .in_ready(in_ready),
        .fire(fire), .zero_ins(zero_ins), .cur_ch(cur_ch),
        .first_ch(first_ch), .last_ch(last_ch)
    );

    cic_comb_chain #(
        .IN_W(IN_W), .N_STG(N_STG), .DIFF_DLY(DIFF_DLY), .N_CH(N_CH), .CH_W(CH_W)
    ) comb_i (
        .clk(clk), .rst_n(rst_n), .step(fire && !zero_ins), .ch(cur_ch),
        .din(in_data), .dout(comb_out)
    );

    cic_integ_chain #(
        .IN_W(IN_W), .N_STG(N_STG), .RATE(RATE), .DIFF_DLY(DIFF_DLY),
        .N_CH(N_CH), .CH_W(CH_W)
    ) integ_i (
        .clk(clk), .rst_n(rst_n), .step(fire), .zero(zero_ins), .ch(cur_ch),
        .din(comb_out), .dout(integ_out)
    );

    // Output register: load on a fired beat, drop valid once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_channel <= '0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
        end else if (fire) begin
            out_valid   <= 1'b1;
            out_data    <= integ_out;
            out_channel <= cur_ch;
            out_sop     <= first_ch;
            out_eop     <= last_ch;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/cic_interp_chk.sv
// Module cic_interp_chk
// Protocol checks on the ports of cic_interp, bound to every instance.
// Keeps its own count of the expected output channel.
module cic_interp_chk #(
    parameter int N_CH  = 4,
    parameter int OUT_W = 12,
    parameter int CH_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data,
    input logic [CH_W-1:0]  out_channel,
    input logic             out_sop,
    input logic             out_eop
);
    logic [CH_W-1:0] exp_ch;

    // Expected channel of the next transferred output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_ch <= '0;
        else if (out_valid && out_ready)
            exp_ch <= (exp_ch == CH_W'(N_CH - 1)) ? '0 : exp_ch + 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_chan_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_channel == exp_ch);

    assert_sop_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == (out_channel == '0)));

    assert_eop_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_eop == (out_channel == CH_W'(N_CH - 1))));

    assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !in_ready);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_channel) && $stable(out_sop) && $stable(out_eop));
endmodule

bind cic_interp cic_interp_chk #(.N_CH(N_CH), .OUT_W(OUT_W), .CH_W(CH_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_channel(out_channel), .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/cic_interp_tb_top.sv
module cic_interp_tb_top;
    localparam int IN_W = 8, N_STG = 3, RATE = 4, DIFF_DLY = 1, N_CH = 4;
    localparam int OUT_W = IN_W + N_STG * $clog2(RATE * DIFF_DLY) - $clog2(RATE);
    localparam int CH_W  = 2;
    localparam int BOX   = RATE * DIFF_DLY;
    localparam int HLEN  = N_STG * (BOX - 1) + 1;

    logic clk = 1'b0, rst_n;
    logic in_valid, in_ready, in_sop, in_eop, out_valid, out_ready, out_sop, out_eop;
    logic signed [IN_W-1:0]  in_data;
    logic signed [OUT_W-1:0] out_data;
    logic [CH_W-1:0]         out_channel;

    cic_interp #(.IN_W(IN_W), .N_STG(N_STG), .RATE(RATE), .DIFF_DLY(DIFF_DLY), .N_CH(N_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_channel(out_channel),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int h [HLEN];
    int hist [N_CH][HLEN];
    int in_q [$];
    int sent [$];
    int in_pos = 0, out_cnt = 0;
    bit acc_prev = 0, stall_prev = 0, done = 0;
    logic [OUT_W-1:0] data_prev;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference impulse response: N_STG-fold convolution of an all-ones window.
    function automatic void build_h();
        int t [HLEN];
        for (int i = 0; i < HLEN; i++) h[i] = (i == 0) ? 1 : 0;
        for (int s = 0; s < N_STG; s++) begin
            for (int i = 0; i < HLEN; i++) begin
                t[i] = 0;
                for (int k = 0; k < BOX; k++) if (i - k >= 0) t[i] += h[i-k];
            end
            for (int i = 0; i < HLEN; i++) h[i] = t[i];
        end
    endfunction

    // One high-rate step of the zero-stuffed moving-sum model for channel c.
    function automatic int model_step(int c, int x);
        int acc = 0;
        for (int i = HLEN - 1; i > 0; i--) hist[c][i] = hist[c][i-1];
        hist[c][0] = x;
        for (int i = 0; i < HLEN; i++) acc += h[i] * hist[c][i];
        return acc;
    endfunction

    task automatic cycle(input bit rnd);
        int produced, ph, ch, x, e;
        @(negedge clk);
        out_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
        if (in_pos < in_q.size()) begin
            in_valid = rnd ? ($urandom % 3 != 0) : 1'b1;
            in_data  = IN_W'(in_q[in_pos]);
            in_sop   = (in_pos % N_CH) == 0;
            in_eop   = (in_pos % N_CH) == N_CH - 1;
        end else begin
            in_valid = 1'b0;
        end
        #1;
        if (acc_prev) chk(out_valid === 1'b1, "R2 output after accept", int'(out_valid), 1);
        if (stall_prev) chk(out_valid === 1'b1 && out_data === data_prev, "R7 hold under stall",
                            int'(out_data), int'($signed(data_prev)));
        produced = out_cnt + (out_valid ? 1 : 0);
        ph = (produced / N_CH) % RATE;
        chk(in_ready === (out_ready && ph == 0), "R4 in_ready gating", int'(in_ready),
            int'(out_ready && ph == 0));
        stall_prev = out_valid && !out_ready;
        data_prev  = out_data;
        if (out_valid && out_ready) begin
            ch = out_cnt % N_CH;
            ph = (out_cnt / N_CH) % RATE;
            x  = 0;
            if (ph == 0) x = sent.pop_front();
            e = model_step(ch, x);
            chk(out_data === OUT_W'(e), "R5 R6 filter output", int'(out_data), e);
            chk(out_channel === CH_W'(ch), "R3 out_channel", int'(out_channel), ch);
            chk(out_sop === (ch == 0) && out_eop === (ch == N_CH - 1), "R3 packet markers",
                int'({out_sop, out_eop}), int'({ch == 0, ch == N_CH - 1}));
            out_cnt++;
        end
        acc_prev = in_valid && in_ready;
        if (acc_prev) begin
            sent.push_back(in_q[in_pos]);
            in_pos++;
        end
    endtask

    task automatic run(input bit rnd);
        while (out_cnt < in_q.size() * RATE) cycle(rnd);
    endtask

    task automatic push_pkt(input int a0, input int a1, input int a2, input int a3);
        in_q.push_back(a0); in_q.push_back(a1); in_q.push_back(a2); in_q.push_back(a3);
    endtask

    initial begin
        automatic int amp [N_CH] = '{127, -128, 1, -77};
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
        out_ready = 1'b1;
        build_h();
        for (int c = 0; c < N_CH; c++) for (int i = 0; i < HLEN; i++) hist[c][i] = 0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        #1;
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 idle after reset",
            int'({out_valid, in_ready}), 1);
        // Directed: one impulse per channel, each followed by a flush.
        for (int c = 0; c < N_CH; c++) begin
            push_pkt(c == 0 ? amp[0] : 0, c == 1 ? amp[1] : 0,
                     c == 2 ? amp[2] : 0, c == 3 ? amp[3] : 0);
            repeat (3) push_pkt(0, 0, 0, 0);
        end
        // Directed: steady extremes reach the output range bounds (R6).
        repeat (5) push_pkt(-128, -128, -128, -128);
        repeat (3) push_pkt(0, 0, 0, 0);
        repeat (5) push_pkt(127, 127, 127, 127);
        repeat (3) push_pkt(0, 0, 0, 0);
        run(0);
        // Random samples with random valid and ready gaps.
        repeat (40) push_pkt($urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128,
                             $urandom_range(0, 255) - 128, $urandom_range(0, 255) - 128);
        run(1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R3 watchdog actual=%0d expected=%0d beats", out_cnt, in_q.size() * RATE);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule